// File: doc/BRIEF.md
# Multi-Beam Complex-Weight Beamformer

The block combines one complex baseband sample from each antenna element into several beams at once. For every beam it multiplies each element's sample by that beam's own complex weight and adds the weighted samples over all elements. The result is one complex output per beam for every accepted input cycle. Steering is done purely by phase and gain, through the complex weights.

Weights are loaded through a small register port. Software writes a desired steering weight per (beam, element) and one calibration correction per element receive path. All beams share the calibration corrections. When either factor is written, the block forms their complex product itself, rounds it and stores it as the effective weight in a shadow bank. A commit strobe copies the whole shadow bank into the active bank in one cycle. This lets steering change from one sample to the next without any beam sum ever mixing old and new weights.

Top module: `mbf_core`

## Requirements
- R1: Each beam output is I = sum(si*wi - sq*wq) and Q = sum(si*wq + sq*wi) over all elements, using that beam's active weights. The sum is then rounded by adding 2^14 and shifting arithmetically right by 15, and saturated to the signed 16-bit range.
- R2: `beam_valid_o` is high exactly two cycles after a cycle with `smp_valid_i` high, and low otherwise. The beam outputs change only when `beam_valid_o` rises for a new result, and hold their value in between.
- R3: Writing a desired weight (`cfg_cal_i`=0) to beam `cfg_beam_i`, element `cfg_elem_i` stores that beam's shadow weight for that element. The stored value is the complex product of the written value and the element's current calibration factor, rounded to Q1.15 (add 2^14, shift right 15) and saturated.
- R4: Writing a calibration factor (`cfg_cal_i`=1) to element `cfg_elem_i` recomputes that element's shadow weight in every beam, using each beam's stored desired weight. `cfg_beam_i` is ignored on such a write.
- R5: Weight and calibration writes alone never change the beam outputs. They reach the outputs only through a commit.
- R6: On a cycle with `commit_i` high, the whole shadow bank as it stood before that cycle's write becomes active. A sample accepted in the commit cycle uses the previous active weights, and samples from the next cycle on use the new ones. A write in the commit cycle lands only in the shadow bank.
- R7: After reset, desired weights and both weight banks are zero and each calibration factor is 0x7FFF + j0. `beam_valid_o` and all beam outputs are zero.
- R8: Saturation applies at both roundings. A desired weight of -32768 times a calibration factor of -32768 (both imaginary 0) gives an effective weight of 32767. A beam sum beyond the 16-bit range clips to 32767 or -32768.
- R9: Element e occupies bits [16e+15:16e] of `smp_i_i`/`smp_q_i`, and beam b occupies bits [16b+15:16b] of `beam_i_o`/`beam_q_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| smp_valid_i | input | 1 | Element samples valid this cycle |
| smp_i_i | input | N_ELEM*16 | Packed in-phase samples, element 0 in the low bits |
| smp_q_i | input | N_ELEM*16 | Packed quadrature samples, element 0 in the low bits |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_cal_i | input | 1 | 0 = desired weight write, 1 = calibration write |
| cfg_beam_i | input | max(1,log2 N_BEAM) | Beam index for desired weight writes |
| cfg_elem_i | input | max(1,log2 N_ELEM) | Element index |
| cfg_wi_i | input | 16 | Real part of written value, Q1.15 |
| cfg_wq_i | input | 16 | Imaginary part of written value, Q1.15 |
| commit_i | input | 1 | Copy shadow bank to active bank |
| beam_valid_o | output | 1 | Beam outputs carry a new result |
| beam_i_o | output | N_BEAM*16 | Packed beam in-phase outputs |
| beam_q_o | output | N_BEAM*16 | Packed beam quadrature outputs |

## Verification
A register write, a commit and an accepted sample can all fall in one cycle. The write must then stay out of the newly active bank, and the sample must still be weighted with the bank that was active before the commit. The bench provokes this in directed steps that write, commit and present a sample together, and in a random phase where the three strobes are drawn independently. A cycle-level model in the bench applies the commit before the write and evaluates the sample against the pre-commit bank. It compares every output cycle against that model.

// File: rtl/mbf_pkg.sv
package mbf_pkg;
  localparam int unsigned SW = 16;
  localparam int unsigned FB = SW - 1;

  typedef logic signed [SW-1:0] smp_t;
  typedef struct packed {
    smp_t re;
    smp_t im;
  } cpx_t;

  // round half up at bit FB, then clip to SW bits
  function automatic smp_t rnd_sat(input longint x);
    longint y, hi, lo;
    hi = (longint'(1) <<< (SW - 1)) - 1;
    lo = -(longint'(1) <<< (SW - 1));
    y  = (x + (longint'(1) <<< (FB - 1))) >>> FB;
    if (y > hi) y = hi;
    else if (y < lo) y = lo;
    return smp_t'(y);
  endfunction

  function automatic cpx_t cmul_rnd(input cpx_t a, input cpx_t b);
    cpx_t r;
    r.re = rnd_sat(longint'(a.re) * longint'(b.re) - longint'(a.im) * longint'(b.im));
    r.im = rnd_sat(longint'(a.re) * longint'(b.im) + longint'(a.im) * longint'(b.re));
    return r;
  endfunction
endpackage

// File: rtl/mbf_wtab.sv
module mbf_wtab
  import mbf_pkg::*;
#(
  parameter  int unsigned N_ELEM = 8,
  parameter  int unsigned N_BEAM = 2,
  localparam int unsigned EW     = (N_ELEM > 1) ? $clog2(N_ELEM) : 1,
  localparam int unsigned BW     = (N_BEAM > 1) ? $clog2(N_BEAM) : 1
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            we_i,
  input  logic                            sel_cal_i,
  input  logic [BW-1:0]                   beam_i,
  input  logic [EW-1:0]                   elem_i,
  input  cpx_t                            wdat_i,
  input  logic                            commit_i,
  output cpx_t [N_BEAM-1:0][N_ELEM-1:0]   act_o
);
  localparam cpx_t CAL_ONE = {1'b0, {(SW-1){1'b1}}, {SW{1'b0}}};

  cpx_t [N_ELEM-1:0] cal_q;
  cpx_t              cal_sel;

  assign cal_sel = cal_q[elem_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cal_q <= {N_ELEM{CAL_ONE}};
    end else if (we_i && sel_cal_i) begin
      cal_q[elem_i] <= wdat_i;
    end
  end

  for (genvar b = 0; b < N_BEAM; b++) begin : g_beam
    cpx_t [N_ELEM-1:0] des_q, shd_q, act_q;
    cpx_t              op_w, op_c, eff;
    logic              hit;

    assign hit  = (beam_i == BW'(b));
    // calibration write reuses stored desired weight; desired write reuses stored cal
    assign op_w = sel_cal_i ? des_q[elem_i] : wdat_i;
    assign op_c = sel_cal_i ? wdat_i : cal_sel;
    assign eff  = cmul_rnd(op_w, op_c);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        des_q <= '0;
        shd_q <= '0;
        act_q <= '0;
      end else begin
        if (commit_i) act_q <= shd_q;
        if (we_i && (sel_cal_i || hit)) shd_q[elem_i] <= eff;
        if (we_i && !sel_cal_i && hit) des_q[elem_i] <= wdat_i;
      end
    end

    assign act_o[b] = act_q;
  end
endmodule

// File: rtl/mbf_cmac.sv
module mbf_cmac
  import mbf_pkg::*;
#(
  parameter  int unsigned N_ELEM = 8,
  localparam int unsigned PW     = 2 * SW + 1,
  localparam int unsigned AW     = PW + $clog2(N_ELEM)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              s1_en_i,
  input  logic              s2_en_i,
  input  cpx_t [N_ELEM-1:0] smp_i,
  input  cpx_t [N_ELEM-1:0] w_i,
  output cpx_t              res_o
);
  logic [N_ELEM-1:0][PW-1:0] pr_all, pi_all;

  for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
    smp_t ar, ai, br, bi;
    logic signed [PW-1:0] pr_d, pi_d, pr_q, pi_q;

    assign ar   = smp_i[e].re;
    assign ai   = smp_i[e].im;
    assign br   = w_i[e].re;
    assign bi   = w_i[e].im;
    assign pr_d = PW'(ar) * PW'(br) - PW'(ai) * PW'(bi);
    assign pi_d = PW'(ar) * PW'(bi) + PW'(ai) * PW'(br);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        pr_q <= '0;
        pi_q <= '0;
      end else if (s1_en_i) begin
        pr_q <= pr_d;
        pi_q <= pi_d;
      end
    end

    assign pr_all[e] = pr_q;
    assign pi_all[e] = pi_q;
  end

  logic signed [AW-1:0] acc_r, acc_i;

  always_comb begin
    acc_r = '0;
    acc_i = '0;
    for (int e = 0; e < N_ELEM; e++) begin
      acc_r = acc_r + AW'($signed(pr_all[e]));
      acc_i = acc_i + AW'($signed(pi_all[e]));
    end
  end

  cpx_t res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
    end else if (s2_en_i) begin
      res_q.re <= rnd_sat(longint'(acc_r));
      res_q.im <= rnd_sat(longint'(acc_i));
    end
  end

  assign res_o = res_q;
endmodule

// File: rtl/mbf_core.sv
module mbf_core
  import mbf_pkg::*;
#(
  parameter  int unsigned N_ELEM = 8,
  parameter  int unsigned N_BEAM = 2,
  localparam int unsigned EW     = (N_ELEM > 1) ? $clog2(N_ELEM) : 1,
  localparam int unsigned BW     = (N_BEAM > 1) ? $clog2(N_BEAM) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   smp_valid_i,
  input  logic [N_ELEM*SW-1:0]   smp_i_i,
  input  logic [N_ELEM*SW-1:0]   smp_q_i,
  input  logic                   cfg_we_i,
  input  logic                   cfg_cal_i,
  input  logic [BW-1:0]          cfg_beam_i,
  input  logic [EW-1:0]          cfg_elem_i,
  input  logic [SW-1:0]          cfg_wi_i,
  input  logic [SW-1:0]          cfg_wq_i,
  input  logic                   commit_i,
  output logic                   beam_valid_o,
  output logic [N_BEAM*SW-1:0]   beam_i_o,
  output logic [N_BEAM*SW-1:0]   beam_q_o
);
  cpx_t [N_ELEM-1:0]              smp_w;
  cpx_t [N_BEAM-1:0][N_ELEM-1:0]  act_w;
  cpx_t [N_BEAM-1:0]              res_w;
  cpx_t                           wdat;
  logic                           v1_q, v2_q;

  assign wdat = {cfg_wi_i, cfg_wq_i};

  for (genvar e = 0; e < N_ELEM; e++) begin : g_unpack
    assign smp_w[e] = {smp_i_i[e*SW +: SW], smp_q_i[e*SW +: SW]};
  end

  mbf_wtab #(
    .N_ELEM (N_ELEM),
    .N_BEAM (N_BEAM)
  ) u_wtab (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .sel_cal_i (cfg_cal_i),
    .beam_i    (cfg_beam_i),
    .elem_i    (cfg_elem_i),
    .wdat_i    (wdat),
    .commit_i  (commit_i),
    .act_o     (act_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= smp_valid_i;
      v2_q <= v1_q;
    end
  end

  for (genvar b = 0; b < N_BEAM; b++) begin : g_beam
    mbf_cmac #(
      .N_ELEM (N_ELEM)
    ) u_cmac (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .s1_en_i (smp_valid_i),
      .s2_en_i (v1_q),
      .smp_i   (smp_w),
      .w_i     (act_w[b]),
      .res_o   (res_w[b])
    );
    assign beam_i_o[b*SW +: SW] = res_w[b].re;
    assign beam_q_o[b*SW +: SW] = res_w[b].im;
  end

  assign beam_valid_o = v2_q;
endmodule

// File: rtl/mbf_core_chk.sv
module mbf_core_chk
  import mbf_pkg::*;
#(
  parameter int unsigned N_ELEM = 8,
  parameter int unsigned N_BEAM = 2
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            smp_valid_i,
  input logic                            cfg_we_i,
  input logic                            commit_i,
  input logic                            beam_valid_o,
  input logic [N_BEAM*SW-1:0]            beam_i_o,
  input logic [N_BEAM*SW-1:0]            beam_q_o,
  input cpx_t [N_BEAM-1:0][N_ELEM-1:0]   act_w
);
  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_valid_i |=> ##1 beam_valid_o); // R2

  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> ##1 !beam_valid_o); // R2

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !smp_valid_i |=> ##1 ($stable(beam_i_o) && $stable(beam_q_o))); // R2

  AST_ACT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !commit_i |=> $stable(act_w)); // R6

  AST_WRITE_SHADOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_we_i && !commit_i) |=> $stable(act_w)); // R5
endmodule

bind mbf_core mbf_core_chk #(
  .N_ELEM (N_ELEM),
  .N_BEAM (N_BEAM)
) chk_i (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .smp_valid_i  (smp_valid_i),
  .cfg_we_i     (cfg_we_i),
  .commit_i     (commit_i),
  .beam_valid_o (beam_valid_o),
  .beam_i_o     (beam_i_o),
  .beam_q_o     (beam_q_o),
  .act_w        (act_w)
);

// File: tb/mbf_core_tb_top.sv
module mbf_core_tb_top;
  localparam int NE = 8;
  localparam int NB = 2;
  localparam int SW = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            smp_valid = 1'b0;
  logic [NE*SW-1:0] smp_i_bus = '0, smp_q_bus = '0;
  logic            cfg_we = 1'b0, cfg_cal = 1'b0, commit = 1'b0;
  logic [0:0]      cfg_beam = '0;
  logic [2:0]      cfg_elem = '0;
  logic [SW-1:0]   cfg_wi = '0, cfg_wq = '0;
  logic            beam_valid;
  logic [NB*SW-1:0] beam_i, beam_q;

  always #5 clk = ~clk;

  mbf_core #(.N_ELEM(NE), .N_BEAM(NB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .smp_valid_i(smp_valid),
    .smp_i_i(smp_i_bus), .smp_q_i(smp_q_bus),
    .cfg_we_i(cfg_we), .cfg_cal_i(cfg_cal), .cfg_beam_i(cfg_beam),
    .cfg_elem_i(cfg_elem), .cfg_wi_i(cfg_wi), .cfg_wq_i(cfg_wq),
    .commit_i(commit), .beam_valid_o(beam_valid),
    .beam_i_o(beam_i), .beam_q_o(beam_q)
  );

  int n_chk = 0, n_err = 0;
  bit done = 0;

  int des_r[NB][NE], des_i[NB][NE], shd_r[NB][NE], shd_i[NB][NE];
  int act_r[NB][NE], act_i[NB][NE], cal_r[NE], cal_i[NE];
  int s_r[NE], s_i[NE];
  bit p1_v, p2_v;
  int p1_r[NB], p1_i[NB], p2_r[NB], p2_i[NB], out_r[NB], out_i[NB];

  function automatic int rs(longint x);
    longint y = (x + 64'sd16384) >>> 15;
    if (y > 32767) y = 32767;
    if (y < -32768) y = -32768;
    return int'(y);
  endfunction

  function automatic void cm(int ar, int ai, int br, int bi, output int r, output int i);
    r = rs(longint'(ar) * br - longint'(ai) * bi);
    i = rs(longint'(ar) * bi + longint'(ai) * br);
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int rnd16();
    return int'($urandom_range(0, 65535)) - 32768;
  endfunction

  task automatic model_reset();
    for (int b = 0; b < NB; b++) begin
      for (int e = 0; e < NE; e++) begin
        des_r[b][e] = 0; des_i[b][e] = 0; shd_r[b][e] = 0; shd_i[b][e] = 0;
        act_r[b][e] = 0; act_i[b][e] = 0;
      end
      p1_r[b] = 0; p1_i[b] = 0; p2_r[b] = 0; p2_i[b] = 0; out_r[b] = 0; out_i[b] = 0;
    end
    for (int e = 0; e < NE; e++) begin cal_r[e] = 32767; cal_i[e] = 0; end
    p1_v = 0; p2_v = 0;
  endtask

  // one clock: drive after negedge, model the edge, check at next negedge
  task automatic step(bit v, bit we, bit sel, int bm, int el, int wr, int wi, bit cmt, string tg);
    smp_valid = v;
    for (int e = 0; e < NE; e++) begin
      smp_i_bus[e*SW +: SW] = 16'(s_r[e]);
      smp_q_bus[e*SW +: SW] = 16'(s_i[e]);
    end
    cfg_we = we; cfg_cal = sel; cfg_beam = 1'(bm); cfg_elem = 3'(el);
    cfg_wi = 16'(wr); cfg_wq = 16'(wi); commit = cmt;
    @(posedge clk);
    p2_v = p1_v;
    for (int b = 0; b < NB; b++) begin p2_r[b] = p1_r[b]; p2_i[b] = p1_i[b]; end
    p1_v = v;
    if (v) begin
      for (int b = 0; b < NB; b++) begin
        longint ar = 0, ai = 0;
        for (int e = 0; e < NE; e++) begin
          ar += longint'(s_r[e]) * act_r[b][e] - longint'(s_i[e]) * act_i[b][e];
          ai += longint'(s_r[e]) * act_i[b][e] + longint'(s_i[e]) * act_r[b][e];
        end
        p1_r[b] = rs(ar); p1_i[b] = rs(ai);
      end
    end
    if (cmt) begin
      for (int b = 0; b < NB; b++)
        for (int e = 0; e < NE; e++) begin act_r[b][e] = shd_r[b][e]; act_i[b][e] = shd_i[b][e]; end
    end
    if (we) begin
      if (sel) begin
        cal_r[el] = wr; cal_i[el] = wi;
        for (int b = 0; b < NB; b++) cm(des_r[b][el], des_i[b][el], wr, wi, shd_r[b][el], shd_i[b][el]);
      end else begin
        des_r[bm][el] = wr; des_i[bm][el] = wi;
        cm(wr, wi, cal_r[el], cal_i[el], shd_r[bm][el], shd_i[bm][el]);
      end
    end
    if (p2_v) for (int b = 0; b < NB; b++) begin out_r[b] = p2_r[b]; out_i[b] = p2_i[b]; end
    @(negedge clk);
    smp_valid = 0; cfg_we = 0; commit = 0;
    chk("R2 valid", int'(beam_valid), int'(p2_v));
    for (int b = 0; b < NB; b++) begin
      chk({tg, " I"}, int'($signed(beam_i[b*SW +: SW])), out_r[b]);
      chk({tg, " Q"}, int'($signed(beam_q[b*SW +: SW])), out_i[b]);
    end
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 0, 0, 0, "R2 hold");
  endtask

  task automatic wr_des(int b, int e, int r, int i);
    step(0, 1, 0, b, e, r, i, 0, "R5 write");
  endtask

  task automatic rnd_smp();
    for (int e = 0; e < NE; e++) begin s_r[e] = rnd16(); s_i[e] = rnd16(); end
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_err++;
      $display("FAIL R2 watchdog act=running exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    model_reset();
    for (int e = 0; e < NE; e++) begin s_r[e] = 0; s_i[e] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    chk("R7 valid", int'(beam_valid), 0);
    chk("R7 beam I", int'(beam_i), 0);
    chk("R7 beam Q", int'(beam_q), 0);
    rnd_smp();
    step(1, 0, 0, 0, 0, 0, 0, 0, "R7 zero weights");
    idle(2);

    // R3 desired write with default cal, then commit
    wr_des(0, 0, 32767, 0);
    wr_des(1, 3, 0, -16384);
    wr_des(0, 5, -20000, 12345);
    step(0, 0, 0, 0, 0, 0, 0, 1, "R3 commit");
    rnd_smp();
    step(1, 0, 0, 0, 0, 0, 0, 0, "R3 effective");
    idle(2);

    // R5 write without commit leaves outputs on old weights
    wr_des(0, 0, -16384, 5000);
    rnd_smp();
    step(1, 0, 0, 0, 0, 0, 0, 0, "R5 no commit");
    idle(2);

    // R6 sample in commit cycle uses old set, next uses new
    rnd_smp();
    step(1, 0, 0, 0, 0, 0, 0, 1, "R6 old set");
    rnd_smp();
    step(1, 0, 0, 0, 0, 0, 0, 0, "R6 new set");
    // R6 write, commit and sample together
    rnd_smp();
    step(1, 1, 0, 0, 1, 30000, -30000, 1, "R6 write+commit");
    rnd_smp();
    step(1, 0, 0, 0, 0, 0, 0, 0, "R6 write excluded");
    idle(2);

    // R4 calibration write hits every beam, beam index ignored
    wr_des(1, 0, 12000, 7000);
    step(0, 1, 1, 1, 0, 0, 32767, 0, "R4 cal write");
    step(0, 0, 0, 0, 0, 0, 0, 1, "R4 commit");
    rnd_smp();
    step(1, 0, 0, 0, 0, 0, 0, 0, "R4 all beams");
    idle(2);

    // R8 saturation of effective weight and of beam sum
    for (int e = 0; e < NE; e++) begin
      step(0, 1, 1, 0, e, -32768, 0, 0, "R8 cal");
      wr_des(0, e, -32768, 0);
    end
    step(0, 0, 0, 0, 0, 0, 0, 1, "R8 commit");
    for (int e = 0; e < NE; e++) begin s_r[e] = 32767; s_i[e] = 0; end
    step(1, 0, 0, 0, 0, 0, 0, 0, "R8 pos");
    idle(2);
    chk("R8 sat pos I", int'($signed(beam_i[SW-1:0])), 32767);
    chk("R8 sat pos Q", int'($signed(beam_q[SW-1:0])), 0);
    for (int e = 0; e < NE; e++) begin s_r[e] = -32768; s_i[e] = 0; end
    step(1, 0, 0, 0, 0, 0, 0, 0, "R8 neg");
    idle(2);
    chk("R8 sat neg I", int'($signed(beam_i[SW-1:0])), -32768);

    // R9 single element lanes
    for (int e = 0; e < NE; e++) begin
      for (int k = 0; k < NE; k++) begin s_r[k] = 0; s_i[k] = 0; end
      s_r[e] = rnd16(); s_i[e] = rnd16();
      step(1, 1, 0, 1, e, rnd16(), rnd16(), 1, "R9 lane");
    end
    idle(2);

    // R1 random mix, weights may change every sample
    for (int n = 0; n < 600; n++) begin
      bit v = ($urandom_range(0, 3) != 0);
      bit we = $urandom_range(0, 1);
      bit sel = ($urandom_range(0, 3) == 0);
      bit cmt = ($urandom_range(0, 2) == 0);
      int wr = ($urandom_range(0, 15) == 0) ? -32768 : rnd16();
      rnd_smp();
      step(v, we, sel, int'($urandom_range(0, NB - 1)), int'($urandom_range(0, NE - 1)),
           wr, rnd16(), cmt, "R1 random");
    end
    idle(2);

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule